// File: doc/BRIEF.md
# Stepper Iris Position Controller

This block servos a lens iris driven by a four-phase stepper motor. It keeps a signed current position and a signed target position. On every step tick, if the two differ, it moves the position one step toward the target and turns the motor phase one notch in the matching direction. The phase index is decoded into a 4-bit coil drive pattern, and the block reports whether a move is still in progress.

Step ticks come from a prescaler on the system clock. A requested rate in steps per second is clamped to a legal range and divided into the clock rate to give a tick period in cycles. Two calibration commands let control logic declare the present mechanical end stop to be the fully open or the fully closed end. A polarity input chooses whether position zero means fully open or fully closed. A new target can be written at any time, and motion continues from where it is toward the latest value.

Top module: `iris_stepper`

## Requirements
- R1: The coil output decodes the phase index as 0 → 4'b0101, 1 → 4'b0110, 2 → 4'b1010, 3 → 4'b1001. Exactly two coil bits are high at all times.
- R2: After reset the position and target are 0, the phase is 0, the coil output is 4'b0101, busy and done are low, and the tick period is CLK_HZ / DEF_PPS cycles.
- R3: On a tick where the position differs from the target, the position changes by exactly one toward the target. When they are equal, the position, phase and coil output hold.
- R4: A step toward a larger position advances the phase by one modulo 4 (0→1→2→3→0). A step toward a smaller position retreats it by one modulo 4 (3→2→1→0→3).
- R5: The tick period is CLK_HZ / r cycles, where r is `pps_in` clamped to the range 1 to CLK_HZ. A new `pps_in` value takes effect at the next tick boundary.
- R6: `busy` is high exactly while the position differs from the target.
- R7: `done` is high for one cycle, in the same cycle that a step makes the position equal to the target. It is low otherwise.
- R8: `cal_open` sets both position and target to 0 when `zero_is_max` is 1, and to TOTAL_STEPS−1 (91 by default) when it is 0. The phase is left unchanged.
- R9: `cal_close` sets both position and target to TOTAL_STEPS−1 when `zero_is_max` is 1, and to 0 when it is 0. The phase is left unchanged.
- R10: Writing a new target during a move redirects the stepping toward that target. The phase continues from its present value, with no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | PPS_W | Requested step rate in steps per second |
| tgt_we | input | 1 | Target write strobe |
| tgt_in | input | POS_W | Signed target position |
| cal_open | input | 1 | Declare the present position to be the fully open end |
| cal_close | input | 1 | Declare the present position to be the fully closed end |
| zero_is_max | input | 1 | Polarity: 1 means position 0 is fully open |
| coil | output | 4 | Coil drive pattern |
| busy | output | 1 | Position differs from target |
| done | output | 1 | One-cycle pulse when a move completes |
| pos_out | output | POS_W | Signed current position |

## Verification
A target write, a calibration strobe and a step tick each take effect at the next rising edge. Position, coil pattern, `busy` and `done` are all registered or decoded from registers, so all of them change on that same edge. The bench drives inputs and samples outputs on falling edges only, so every result is read half a cycle after the edge that produced it.

Step timing is checked by counting the falling edges between successive position changes against CLK_HZ divided by the clamped rate. The first interval after each write or rate change is skipped, because the prescaler phase at that moment is arbitrary. A rate change is always followed by at least two old periods of idle, so the new reload is already in use when the move begins.

// File: rtl/iris_pkg.sv
package iris_pkg;

   typedef enum logic [1:0] {
      DIR_HOLD = 2'd0,
      DIR_UP   = 2'd1,
      DIR_DOWN = 2'd2
   } step_dir_e;

   // Phase to coil pattern: upper pair follows phase[1], lower pair follows
   // phase[1]^phase[0]; a pair reads 01 when its select is low, 10 when high.
   function automatic logic [3:0] coil_of(input logic [1:0] ph);
      logic [1:0] hi_pair;
      logic [1:0] lo_pair;
      hi_pair = ph[1] ? 2'b10 : 2'b01;
      lo_pair = (ph[1] ^ ph[0]) ? 2'b10 : 2'b01;
      return {hi_pair, lo_pair};
   endfunction

endpackage

// File: rtl/iris_tick_gen.sv
module iris_tick_gen #(
   parameter int CLK_HZ  = 1000,
   parameter int DEF_PPS = 100,
   parameter int PPS_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PPS_W-1:0] pps_in,
   output logic             tick
);
   localparam int CNT_W = $clog2(CLK_HZ + 1);
   localparam logic [31:0] CLK_HZ_U = 32'(CLK_HZ);
   localparam int DEF_CLAMP = (DEF_PPS < 1) ? 1 : ((DEF_PPS > CLK_HZ) ? CLK_HZ : DEF_PPS);
   localparam logic [CNT_W-1:0] DEF_RELOAD = CNT_W'(CLK_HZ / DEF_CLAMP);
   localparam logic [CNT_W-1:0] CNT_ONE = 1;

   logic [31:0]      pps_w;
   logic [31:0]      pps_cl;
   logic [31:0]      quot;
   logic [CNT_W-1:0] reload_c;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] period_q;

   // R5: clamp the request to 1..CLK_HZ and divide into the clock rate
   always_comb begin
      pps_w = 32'(pps_in);
      if (pps_w == 32'd0)
         pps_cl = 32'd1;
      else if (pps_w > CLK_HZ_U)
         pps_cl = CLK_HZ_U;
      else
         pps_cl = pps_w;
      quot     = CLK_HZ_U / pps_cl;
      reload_c = quot[CNT_W-1:0];
   end

   assign tick = (cnt == period_q - CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         period_q <= DEF_RELOAD;
      end else if (tick) begin
         cnt      <= '0;
         period_q <= reload_c;
      end else begin
         cnt <= cnt + CNT_ONE;
      end
   end

   a_r5_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < period_q);

   a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && reload_c != CNT_ONE) |=> !tick);

endmodule

// File: rtl/iris_step_core.sv
module iris_step_core
   import iris_pkg::*;
#(
   parameter int POS_W       = 8,
   parameter int TOTAL_STEPS = 92
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    tgt_we,
   input  logic signed [POS_W-1:0] tgt_in,
   input  logic                    cal_open,
   input  logic                    cal_close,
   input  logic                    zero_is_max,
   output logic signed [POS_W-1:0] pos,
   output logic signed [POS_W-1:0] tgt,
   output step_dir_e               dir,
   output logic                    done
);
   localparam logic signed [POS_W-1:0] LAST_POS = POS_W'(TOTAL_STEPS - 1);
   localparam logic signed [POS_W-1:0] ONE      = 1;
   localparam logic signed [POS_W-1:0] ZERO     = 0;

   logic                    cal_any;
   logic signed [POS_W-1:0] cal_val;
   logic signed [POS_W-1:0] pos_nxt;
   logic signed [POS_W-1:0] tgt_nxt;

   assign cal_any = cal_open | cal_close;

   // R8 / R9: open wins when both strobes arrive together
   always_comb begin
      if (cal_open)
         cal_val = zero_is_max ? ZERO : LAST_POS;
      else
         cal_val = zero_is_max ? LAST_POS : ZERO;
   end

   // R3 / R4: one step per tick toward the registered target
   always_comb begin
      dir = DIR_HOLD;
      if (!cal_any && tick && (pos != tgt))
         dir = (tgt > pos) ? DIR_UP : DIR_DOWN;
      case (dir)
         DIR_UP:   pos_nxt = pos + ONE;
         DIR_DOWN: pos_nxt = pos - ONE;
         default:  pos_nxt = pos;
      endcase
      tgt_nxt = tgt_we ? tgt_in : tgt;   // R10: latest target always wins
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos  <= '0;
         tgt  <= '0;
         done <= 1'b0;
      end else if (cal_any) begin
         pos  <= cal_val;
         tgt  <= cal_val;
         done <= 1'b0;
      end else begin
         pos  <= pos_nxt;
         tgt  <= tgt_nxt;
         done <= (dir != DIR_HOLD) && (pos_nxt == tgt_nxt);   // R7
      end
   end

   a_r3_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_any |=> (pos == $past(pos)) || (pos == $past(pos) + ONE) || (pos == $past(pos) - ONE));

   a_r7_done_after_move: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pos != $past(pos)) && (pos == tgt));

   a_r8_open_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_open && zero_is_max) |=> (pos == ZERO) && (tgt == ZERO));

   a_r9_close_last: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_close && !cal_open && zero_is_max) |=> (pos == LAST_POS) && (tgt == LAST_POS));

endmodule

// File: rtl/iris_phase_seq.sv
module iris_phase_seq
   import iris_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  step_dir_e dir,
   output logic [3:0] coil
);
   logic [1:0] phase;

   // R4: phase follows the sign of the step, wrapping modulo 4
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= 2'd0;
      else if (dir == DIR_UP)
         phase <= phase + 2'd1;
      else if (dir == DIR_DOWN)
         phase <= phase - 2'd1;
   end

   assign coil = coil_of(phase);   // R1

   a_r4_phase_up: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_UP) |=> phase == $past(phase) + 2'd1);

   a_r4_phase_down: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_DOWN) |=> phase == $past(phase) - 2'd1);

   a_r1_two_coils: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(coil) == 2);

endmodule

// File: rtl/iris_stepper.sv
module iris_stepper
   import iris_pkg::*;
#(
   parameter int CLK_HZ      = 1000,
   parameter int DEF_PPS     = 100,
   parameter int PPS_W       = 16,
   parameter int POS_W       = 8,
   parameter int TOTAL_STEPS = 92
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PPS_W-1:0]        pps_in,
   input  logic                    tgt_we,
   input  logic signed [POS_W-1:0] tgt_in,
   input  logic                    cal_open,
   input  logic                    cal_close,
   input  logic                    zero_is_max,
   output logic [3:0]              coil,
   output logic                    busy,
   output logic                    done,
   output logic signed [POS_W-1:0] pos_out
);
   localparam int POS_MAX = (1 << (POS_W - 1)) - 1;

   generate
      if (CLK_HZ < 1)
         $error("iris_stepper: CLK_HZ must be at least 1");
      if (PPS_W < 1 || PPS_W > 32)
         $error("iris_stepper: PPS_W must lie in 1..32");
      if (POS_W < 2 || POS_W > 31)
         $error("iris_stepper: POS_W must lie in 2..31");
      if (TOTAL_STEPS < 1 || TOTAL_STEPS - 1 > POS_MAX)
         $error("iris_stepper: TOTAL_STEPS must fit the signed position");
   endgenerate

   logic                    tick;
   step_dir_e               dir;
   logic signed [POS_W-1:0] pos;
   logic signed [POS_W-1:0] tgt;

   iris_tick_gen #(
      .CLK_HZ (CLK_HZ),
      .DEF_PPS(DEF_PPS),
      .PPS_W  (PPS_W)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .pps_in(pps_in),
      .tick  (tick)
   );

   iris_step_core #(
      .POS_W      (POS_W),
      .TOTAL_STEPS(TOTAL_STEPS)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .tgt_we     (tgt_we),
      .tgt_in     (tgt_in),
      .cal_open   (cal_open),
      .cal_close  (cal_close),
      .zero_is_max(zero_is_max),
      .pos        (pos),
      .tgt        (tgt),
      .dir        (dir),
      .done       (done)
   );

   iris_phase_seq u_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .dir  (dir),
      .coil (coil)
   );

   assign busy    = (pos != tgt);   // R6
   assign pos_out = pos;

   a_r6_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !tgt_we && !cal_open && !cal_close) |=> $stable(pos_out) && $stable(coil));

endmodule

// File: tb/iris_stepper_tb.sv
module iris_stepper_tb;
   localparam int CLK_HZ = 12;
   localparam int TOTAL  = 92;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [7:0]        pps_in = 8'd3;
   logic              tgt_we = 1'b0;
   logic signed [7:0] tgt_in = '0;
   logic              cal_open = 1'b0;
   logic              cal_close = 1'b0;
   logic              zero_is_max = 1'b1;
   logic [3:0]        coil;
   logic              busy;
   logic              done;
   logic signed [7:0] pos_out;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   int exp_phase = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   iris_stepper #(
      .CLK_HZ(CLK_HZ), .DEF_PPS(3), .PPS_W(8), .POS_W(8), .TOTAL_STEPS(TOTAL)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .tgt_we(tgt_we), .tgt_in(tgt_in),
      .cal_open(cal_open), .cal_close(cal_close), .zero_is_max(zero_is_max),
      .coil(coil), .busy(busy), .done(done), .pos_out(pos_out)
   );

   function automatic logic [3:0] pat(input int ph);
      case (ph & 3)
         0: return 4'b0101;
         1: return 4'b0110;
         2: return 4'b1010;
         default: return 4'b1001;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         nfail++;
         $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 150000);
         summary();
      end
   end

   task automatic write_tgt(input int t);
      tgt_in = 8'(t);
      tgt_we = 1'b1;
      @(negedge clk);
      tgt_we = 1'b0;
   endtask

   // Follows the move step by step until pos reaches exit_pos (and idles, if exit_pos is the target)
   task automatic watch(input int tgt, input int exit_pos, input int period);
      int last = pos_out;
      int gap = 0;
      int steps = 0;
      int guard = 0;
      int sgn;
      while ((pos_out != exit_pos || (exit_pos == tgt && busy)) && guard < 5000) begin
         @(negedge clk);
         gap++;
         guard++;
         if (pos_out != last) begin
            sgn = (tgt > last) ? 1 : -1;
            chk(pos_out == last + sgn, "R3 unit step toward target", pos_out, last + sgn);
            exp_phase = (exp_phase + sgn + 4) % 4;
            chk(coil == pat(exp_phase), "R4/R1 phase and coil", coil, pat(exp_phase));
            if (steps > 0)
               chk(gap == period, "R5 tick period", gap, period);
            chk(done == (pos_out == tgt), "R7 done on arrival", done, pos_out == tgt);
            chk(busy == (pos_out != tgt), "R6 busy", busy, pos_out != tgt);
            steps++;
            gap = 0;
            last = pos_out;
         end else begin
            chk(done == 1'b0, "R7 done only on arrival", done, 0);
         end
      end
      chk(guard < 5000, "R3 move completes", guard, 5000);
   endtask

   task automatic hold_check(input int tgt, input int period);
      logic [3:0] c0 = coil;
      for (int i = 0; i < 3 * period + 2; i++) begin
         @(negedge clk);
         chk(pos_out == tgt && coil == c0 && !done && !busy, "R3 hold when equal",
             pos_out, tgt);
      end
   endtask

   task automatic move(input int tgt, input int period);
      write_tgt(tgt);
      watch(tgt, tgt, period);
      hold_check(tgt, period);
   endtask

   task automatic set_rate(input int pps);
      pps_in = 8'(pps);
      repeat (30) @(negedge clk);
   endtask

   task automatic calib(input bit open, input bit zim, input int exp_pos);
      logic [3:0] c0 = coil;
      zero_is_max = zim;
      cal_open = open;
      cal_close = !open;
      @(negedge clk);
      cal_open = 1'b0;
      cal_close = 1'b0;
      if (open)
         chk(pos_out == exp_pos && !busy, "R8 open calibration", pos_out, exp_pos);
      else
         chk(pos_out == exp_pos && !busy, "R9 close calibration", pos_out, exp_pos);
      chk(coil == c0 && !done, "R8/R9 phase kept", coil, c0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk(pos_out == 0, "R2 reset position", pos_out, 0);
      chk(coil == 4'b0101, "R2 reset coil", coil, 4'b0101);
      chk(!busy && !done, "R2 reset flags", {busy, done}, 0);

      move(10, 4);          // R5 default rate 12/3
      set_rate(0);          // R5 clamp low: period 12
      move(-5, 12);
      set_rate(100);        // R5 clamp high: period 1
      move(7, 1);
      set_rate(5);          // period 2
      move(3, 2);
      set_rate(4);          // period 3
      // R10: redirect mid-move
      write_tgt(30);
      watch(30, 5, 3);
      write_tgt(2);
      watch(2, 2, 3);
      hold_check(2, 3);
      chk(pos_out == 2, "R10 redirected target reached", pos_out, 2);

      calib(1'b1, 1'b1, 0);
      calib(1'b0, 1'b1, TOTAL - 1);
      calib(1'b0, 1'b0, 0);
      calib(1'b1, 1'b0, TOTAL - 1);
      move(88, 3);
      summary();
   end
endmodule